// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block compares the effective address of every load and store against two programmable watchpoints and raises a hit before the access is allowed to complete. Each watchpoint is a doubleword-granular address window, from a base doubleword up to a programmable number of further doublewords. The window is qualified by the privilege of the access, its translation mode and its direction. A register port lets software write and read back the two base registers and the two control registers.

A hit is reported one cycle after the request, with the same timing as store data travelling down the pipeline. It comes with the status word a data storage interrupt would report, the interrupt vector and the faulting effective address. Interrupt delivery and suppression of the access are left to the surrounding pipeline.

The upper end of each window is held precomputed in a register. That register is refreshed on the cycle after any register write, and hits are withheld while the refresh is pending.

Top module: `dwatch_unit`

## Requirements
- R1: Register select `reg_sel` encodes 2'b00 = base of watchpoint 0, 2'b01 = base of watchpoint 1, 2'b10 = control of watchpoint 0, 2'b11 = control of watchpoint 1. A base register keeps only address bits 63:3, and `reg_rdata` returns those bits with bits 2:0 reading as zero.
- R2: A control register keeps 16 bits. It reads back zero-extended to 64 bits, and bit 1 (privileged non-hypervisor enable) is stored and read back but never qualifies a match.
- R3: Address bits 63:3 of an access match a watchpoint when base ≤ addr ≤ base + N, where N is control bits 15:10 counted in doublewords, so N = 0 covers a single doubleword. Both bounds are unsigned compares, and the sum base + N wraps modulo 2^61.
- R4: After a write to any register (`reg_wr` high at a clock edge), a request presented in the following cycle never hits. From the cycle after that, the window reflects the new register values.
- R5: A privileged access (`req_priv` = 1) needs control bit 2. A problem-state access needs control bit 0.
- R6: With control bit 3 = 0, `req_virt` must equal control bit 4 for a match. With bit 3 = 1, `req_virt` is ignored.
- R7: A load needs control bit 5 and a store (`req_store` = 1) needs control bit 6.
- R8: When control bit 7 is set and the access is privileged, address bit 63 is treated as zero for the range compare.
- R9: Only a valid request of class 2'b00 (cache access) can hit. Class 2'b01 (touch), 2'b10 (sync) and 2'b11 (flush) never hit.
- R10: `hit` is registered, high in the cycle after a matching request. While `hit` is high, `hit_status` is 32'h0040_0000, or'd with 32'h0200_0000 for a store, `hit_vector` is 12'h300 and `hit_addr` holds the request's full effective address. While `hit` is low, `hit_status` and `hit_vector` are zero.
- R11: Reset clears all base, control and upper-limit registers, the refresh-pending flag and `hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request valid |
| req_addr | input | 64 | Effective address of the access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_virt | input | 1 | Translation mode of the access |
| req_priv | input | 1 | Privileged access |
| req_class | input | 2 | Operation class |
| hit | output | 1 | Watchpoint hit, one cycle after the request |
| hit_status | output | 32 | Status word to report |
| hit_vector | output | 12 | Interrupt vector for the hit |
| hit_addr | output | 64 | Faulting effective address |

## Verification
A request driven at a falling edge is registered at the next rising edge, so its `hit`, status, vector and address are sampled at the falling edge one cycle later. The bench issues one request per cycle and checks each one at that point against an arithmetic model of the window. A register write is followed by one cycle in which requests are kept idle. The only exception is the dedicated refresh test, which places a matching request in that cycle and expects no hit. `reg_rdata` is combinational and is read at the falling edge after the write.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

    localparam int CTRL_W    = 16;
    localparam int RANGE_LSB = 10;
    localparam int RANGE_W   = 6;

    // control bit positions
    localparam int CB_PRO    = 0;
    localparam int CB_PNH    = 1;
    localparam int CB_HYP    = 2;
    localparam int CB_WT     = 3;
    localparam int CB_WTI    = 4;
    localparam int CB_DR     = 5;
    localparam int CB_DW     = 6;
    localparam int CB_HRAMMC = 7;

    localparam logic [31:0] STAT_WATCH = 32'h0040_0000;
    localparam logic [31:0] STAT_STORE = 32'h0200_0000;
    localparam logic [11:0] DSI_VECTOR = 12'h300;

    typedef enum logic [1:0] {
        ACC_CACHE = 2'b00,
        ACC_TOUCH = 2'b01,
        ACC_SYNC  = 2'b10,
        ACC_FLUSH = 2'b11
    } acc_class_e;

    // qualifier fields taken out of a control register
    typedef struct packed {
        logic pro_en;
        logic hyp_en;
        logic xlat_any;
        logic xlat_val;
        logic rd_en;
        logic wr_en;
        logic top_strip;
    } wp_mode_t;

    function automatic wp_mode_t mode_of(input logic [CTRL_W-1:0] c);
        wp_mode_t m;
        m.pro_en    = c[CB_PRO];
        m.hyp_en    = c[CB_HYP];
        m.xlat_any  = c[CB_WT];
        m.xlat_val  = c[CB_WTI];
        m.rd_en     = c[CB_DR];
        m.wr_en     = c[CB_DW];
        m.top_strip = c[CB_HRAMMC];
        return m;
    endfunction

    function automatic logic mode_ok(input wp_mode_t m, input logic virt,
                                     input logic priv, input logic store);
        logic priv_ok;
        logic xlat_ok;
        logic dir_ok;
        priv_ok = priv ? m.hyp_en : m.pro_en;
        xlat_ok = m.xlat_any | (virt == m.xlat_val);
        dir_ok  = store ? m.wr_en : m.rd_en;
        return priv_ok & xlat_ok & dir_ok;
    endfunction

endpackage

// File: rtl/dwatch_regs.sv
module dwatch_regs
    import dwatch_pkg::*;
#(
    parameter int AW     = 64,
    parameter int NUM_WP = 2,
    parameter int SELW   = $clog2(NUM_WP) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [SELW-1:0] sel,
    input  logic [AW-1:0]   wdata,
    output logic [AW-1:0]   rdata,
    output logic [AW-1:3]   base [NUM_WP],
    output logic [AW-1:3]   lim  [NUM_WP],
    output wp_mode_t        mode [NUM_WP],
    output logic            pending
);
    localparam int IDXW = SELW - 1;
    localparam int DWW  = AW - 3;

    logic [CTRL_W-1:0] ctrl_q [NUM_WP];
    logic [IDXW-1:0]   idx;
    logic              is_ctrl;

    assign idx     = sel[IDXW-1:0];
    assign is_ctrl = sel[SELW-1];

    generate
        for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
            always_ff @(posedge clk) begin
                if (rst) begin
                    base[i]   <= '0;
                    ctrl_q[i] <= '0;
                    lim[i]    <= '0;
                end else begin
                    if (wr && (idx == IDXW'(i))) begin
                        if (is_ctrl)
                            ctrl_q[i] <= wdata[CTRL_W-1:0];
                        else
                            base[i] <= wdata[AW-1:3];
                    end
                    if (pending)
                        lim[i] <= base[i] + DWW'(ctrl_q[i][RANGE_LSB +: RANGE_W]);
                end
            end
            assign mode[i] = mode_of(ctrl_q[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else
            pending <= wr;
    end

    always_comb begin
        if (is_ctrl)
            rdata = AW'(ctrl_q[idx]);
        else
            rdata = {base[idx], 3'b000};
    end

endmodule

// File: rtl/dwatch_cmp.sv
module dwatch_cmp
    import dwatch_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:3] base,
    input  logic [AW-1:3] lim,
    input  wp_mode_t      mode,
    input  logic [AW-1:3] addr,
    input  logic          store,
    input  logic          virt,
    input  logic          priv,
    output logic          match
);
    localparam int DWW = AW - 3;

    logic [AW-1:3] a_eff;
    logic [DWW:0]  lo_diff;
    logic [DWW:0]  hi_diff;
    logic          in_window;

    always_comb begin
        a_eff = addr;
        if (priv && mode.top_strip)
            a_eff[AW-1] = 1'b0;
        lo_diff   = {1'b0, a_eff} - {1'b0, base};
        hi_diff   = {1'b0, lim} - {1'b0, a_eff};
        in_window = !lo_diff[DWW] && !hi_diff[DWW];
        match     = in_window && mode_ok(mode, virt, priv, store);
    end

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
    import dwatch_pkg::*;
#(
    parameter int AW     = 64,
    parameter int NUM_WP = 2,
    localparam int SELW  = $clog2(NUM_WP) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [SELW-1:0] reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_store,
    input  logic            req_virt,
    input  logic            req_priv,
    input  logic [1:0]      req_class,
    output logic            hit,
    output logic [31:0]     hit_status,
    output logic [11:0]     hit_vector,
    output logic [AW-1:0]   hit_addr
);
    logic [AW-1:3] base [NUM_WP];
    logic [AW-1:3] lim  [NUM_WP];
    wp_mode_t      mode [NUM_WP];
    logic          pending;
    logic [NUM_WP-1:0] wp_match;
    logic          eligible;
    logic          hit_d;
    acc_class_e    cls;

    dwatch_regs #(.AW(AW), .NUM_WP(NUM_WP), .SELW(SELW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .base    (base),
        .lim     (lim),
        .mode    (mode),
        .pending (pending)
    );

    generate
        for (genvar i = 0; i < NUM_WP; i++) begin : g_cmp
            dwatch_cmp #(.AW(AW)) u_cmp (
                .base  (base[i]),
                .lim   (lim[i]),
                .mode  (mode[i]),
                .addr  (req_addr[AW-1:3]),
                .store (req_store),
                .virt  (req_virt),
                .priv  (req_priv),
                .match (wp_match[i])
            );
        end
    endgenerate

    assign cls      = acc_class_e'(req_class);
    assign eligible = req_valid && (cls == ACC_CACHE) && !pending;
    assign hit_d    = eligible && (|wp_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit        <= 1'b0;
            hit_status <= '0;
            hit_vector <= '0;
            hit_addr   <= '0;
        end else begin
            hit <= hit_d;
            if (hit_d) begin
                hit_status <= STAT_WATCH | (req_store ? STAT_STORE : 32'h0);
                hit_vector <= DSI_VECTOR;
                hit_addr   <= req_addr;
            end else begin
                hit_status <= '0;
                hit_vector <= '0;
            end
        end
    end

endmodule

// File: rtl/dwatch_chk.sv
module dwatch_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          req_valid,
    input logic [1:0]    req_class,
    input logic          req_store,
    input logic [AW-1:0] req_addr,
    input logic          hit,
    input logic [31:0]   hit_status,
    input logic [11:0]   hit_vector,
    input logic [AW-1:0] hit_addr
);

    AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ##1 !hit); // R4

    AST_ONLY_CACHE_REQ: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(req_valid && req_class == 2'b00)); // R9

    AST_STATUS_BITS: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_status[22] && hit_status[25] == $past(req_store)
                 && (hit_status & ~32'h0240_0000) == 32'h0)); // R10

    AST_VECTOR_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_vector == 12'h300); // R10

    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_addr == $past(req_addr)); // R10

    AST_QUIET_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_status == 32'h0 && hit_vector == 12'h0)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> !hit); // R11

endmodule

bind dwatch_unit dwatch_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .req_store  (req_store),
    .req_addr   (req_addr),
    .hit        (hit),
    .hit_status (hit_status),
    .hit_vector (hit_vector),
    .hit_addr   (hit_addr)
);

// File: tb/tb_dwatch_unit.sv
module tb_dwatch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        req_valid;
    logic [63:0] req_addr;
    logic        req_store;
    logic        req_virt;
    logic        req_priv;
    logic [1:0]  req_class;
    logic        hit;
    logic [31:0] hit_status;
    logic [11:0] hit_vector;
    logic [63:0] hit_addr;

    always #5 clk = ~clk;

    dwatch_unit dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_store(req_store), .req_virt(req_virt),
        .req_priv(req_priv), .req_class(req_class), .hit(hit),
        .hit_status(hit_status), .hit_vector(hit_vector), .hit_addr(hit_addr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [63:0] sh_base [2];
    logic [15:0] sh_ctrl [2];

    localparam logic [63:0] BASE0 = 64'h0000_0040_0000_1000;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // caller is at a falling edge; returns at a falling edge with the refresh done
    task automatic wr_reg(input logic [1:0] sel, input logic [63:0] data);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel[1]) sh_ctrl[sel[0]] = data[15:0];
        else        sh_base[sel[0]] = {data[63:3], 3'b000};
        @(negedge clk);
    endtask

    function automatic bit model(input logic [63:0] addr, input bit st, input bit v,
                                 input bit p, input logic [1:0] cls, input bit val);
        bit any = 0;
        for (int w = 0; w < 2; w++) begin
            logic [15:0] c;
            logic [60:0] a;
            logic [60:0] b;
            logic [60:0] top;
            c = sh_ctrl[w];
            a = addr[63:3];
            if (p && c[7]) a[60] = 1'b0;
            b   = sh_base[w][63:3];
            top = b + 61'(c[15:10]);
            if (a >= b && a <= top && (p ? c[2] : c[0]) && (c[3] || v == c[4])
                && (st ? c[6] : c[5]))
                any = 1;
        end
        return val && cls == 2'b00 && any;
    endfunction

    // caller is at a falling edge; one request, checked one cycle later
    task automatic do_req(input logic [63:0] addr, input bit st, input bit v, input bit p,
                          input logic [1:0] cls, input bit val, input string tag);
        bit e;
        e = model(addr, st, v, p, cls, val);
        req_valid = val; req_addr = addr; req_store = st;
        req_virt = v; req_priv = p; req_class = cls;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " hit"}, 64'(hit), 64'(e));
        check("R10 status", 64'(hit_status),
              e ? 64'(32'h0040_0000 | (st ? 32'h0200_0000 : 32'h0)) : 64'h0);
        check("R10 vector", 64'(hit_vector), e ? 64'h300 : 64'h0);
        if (e) check("R10 fault addr", hit_addr, addr);
    endtask

    function automatic logic [63:0] probe(input int k, input int rng);
        case (k)
            0: return BASE0 - 64'd8;
            1: return BASE0;
            2: return BASE0 + 64'd7;
            3: return BASE0 + 64'(rng * 8);
            4: return BASE0 + 64'(rng * 8 + 8);
            default: return BASE0 | 64'h8000_0000_0000_0000;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ranges [3] = '{0, 3, 63};
        rst = 1'b1; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        req_valid = 0; req_addr = 0; req_store = 0; req_virt = 0; req_priv = 0; req_class = 0;
        sh_base[0] = 0; sh_base[1] = 0; sh_ctrl[0] = 0; sh_ctrl[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check("R11 hit after reset", 64'(hit), 64'h0);
        for (int s = 0; s < 4; s++) begin
            reg_sel = 2'(s);
            #1 check("R11 register clear", reg_rdata, 64'h0);
        end
        do_req(64'h0, 0, 0, 0, 2'b00, 1, "R11 R3 zero window");

        // R1 / R2 readback
        wr_reg(2'b00, 64'hDEAD_BEEF_0123_4567);
        reg_sel = 2'b00; #1 check("R1 base0 readback", reg_rdata, 64'hDEAD_BEEF_0123_4560);
        wr_reg(2'b01, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_sel = 2'b01; #1 check("R1 base1 readback", reg_rdata, 64'hFFFF_FFFF_FFFF_FFF8);
        reg_sel = 2'b00; #1 check("R1 base0 kept", reg_rdata, 64'hDEAD_BEEF_0123_4560);
        wr_reg(2'b10, 64'hFFFF_FFFF_FFFF_FFFF);
        reg_sel = 2'b10; #1 check("R2 ctrl0 readback", reg_rdata, 64'h0000_0000_0000_FFFF);
        wr_reg(2'b11, 64'h1234_5678_0000_0002);
        reg_sel = 2'b11; #1 check("R2 ctrl1 readback", reg_rdata, 64'h0000_0000_0000_0002);

        // R2: only bit 1 as privilege enable -> never matches
        wr_reg(2'b10, 64'h0);
        wr_reg(2'b01, BASE0);
        wr_reg(2'b11, 64'h0000_0000_0000_FC7A);
        for (int p = 0; p < 2; p++)
            do_req(BASE0, 0, 0, p[0], 2'b00, 1, "R2 R5 pnh bit inert");

        // near-exhaustive sweep of watchpoint 0 qualifiers, range and probe addresses
        wr_reg(2'b11, 64'h0);
        wr_reg(2'b00, BASE0);
        foreach (ranges[ri]) begin
            for (int c8 = 0; c8 < 256; c8++) begin
                wr_reg(2'b10, 64'((ranges[ri] << 10) | c8));
                for (int m = 0; m < 8; m++)
                    for (int k = 0; k < 6; k++)
                        do_req(probe(k, ranges[ri]), m[0], m[1], m[2], 2'b00, 1,
                               "R3 R5 R6 R7 R8 sweep");
            end
        end

        // R9 classes and valid
        wr_reg(2'b10, 64'h0000_0000_0000_0C6F);
        do_req(BASE0, 1, 0, 1, 2'b00, 1, "R9 cache access");
        for (int cl = 1; cl < 4; cl++)
            do_req(BASE0, 1, 0, 1, 2'(cl), 1, "R9 non-cache class");
        do_req(BASE0, 1, 0, 1, 2'b00, 0, "R9 invalid request");

        // R4 refresh window: write the same value, request right away
        reg_wr = 1'b1; reg_sel = 2'b10; reg_wdata = 64'h0000_0000_0000_0C6F;
        @(negedge clk);
        reg_wr = 1'b0;
        req_valid = 1; req_addr = BASE0; req_store = 0; req_virt = 0;
        req_priv = 1; req_class = 2'b00;
        @(negedge clk);
        req_valid = 0;
        check("R4 no hit while refresh pending", 64'(hit), 64'h0);
        do_req(BASE0, 0, 0, 1, 2'b00, 1, "R4 hit after refresh");
        // R4 new range becomes effective after refresh
        wr_reg(2'b10, 64'h0000_0000_0000_146F);
        do_req(BASE0 + 64'd40, 0, 0, 1, 2'b00, 1, "R4 widened range");

        // watchpoint 1 on its own, including a window that wraps
        wr_reg(2'b10, 64'h0);
        wr_reg(2'b01, 64'h0000_0000_0000_2000);
        wr_reg(2'b11, 64'h0000_0000_0000_086F);
        for (int k = 0; k < 5; k++)
            do_req(64'h1FF8 + 64'(k * 8), k[0], 1, 0, 2'b00, 1, "R1 R3 watchpoint1");
        wr_reg(2'b01, 64'hFFFF_FFFF_FFFF_FFF8);
        do_req(64'hFFFF_FFFF_FFFF_FFF8, 0, 0, 1, 2'b00, 1, "R3 wrapped window");
        do_req(64'h0, 0, 0, 1, 2'b00, 1, "R3 wrapped low end");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule